// File: doc/BRIEF.md
# LCD Dot Clock Generator

This block derives the pixel (dot) clock for an LCD panel from the controller core clock. It also produces a one-cycle update enable that the pixel data path uses to change the data bus, so that the bus is stable around the panel's sampling edge. The dot clock comes from a programmable divider with 50% duty cycle, or runs at the full core rate when bypassed. A divider value of zero is treated the same as bypass.

Two activity modes are offered. In the always-running mode, which suits active-matrix panels, the dot clock toggles continuously. In the gated mode it runs only while the display-active input is high and is held low otherwise. The edge on which data is launched is selectable. By default data changes on the falling dot clock edge, and it can be moved to the rising edge. A new divider value is picked up only at the start of a dot clock period, so a reprogramming never produces a shortened phase.

Top module: `lcd_dotclk_gen`

## Requirements
- R1: With bypass low and a divider value N (N >= 1), the dot clock is high for exactly N core cycles and then low for exactly N core cycles, giving a period of 2N core cycles.
- R2: With bypass high, the dot clock follows the core clock: it is high during the high phase of the core clock and low during the low phase. upd_en is held high while the clock runs.
- R3: A divider value of 0 with bypass low behaves exactly as R2.
- R4: In divided mode, upd_en is high for one core cycle, namely the cycle right before each dot clock edge at which data is launched. With launch_rise = 0 this is the falling edge; with launch_rise = 1 it is the rising edge. upd_en is low in every other cycle.
- R5: With clk_gated = 0 (always-running mode), the dot clock runs as in R1/R2 whatever the level of disp_active.
- R6: With clk_gated = 1, while disp_active is low the dot clock is held low and upd_en is low, in both divided and bypass operation. While disp_active is high the clock runs.
- R7: A change of div_val takes effect at the next rising edge of the dot clock. The high and low phases already in progress, and those still to come before that edge, keep the old length.
- R8: While rst is high the dot clock and upd_en are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller core clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Divider value N; 0 selects full core rate |
| bypass | input | 1 | 1 = dot clock at core clock rate |
| launch_rise | input | 1 | 0 = launch data on falling dot clock edge, 1 = rising |
| clk_gated | input | 1 | 0 = always running, 1 = run only while disp_active |
| disp_active | input | 1 | Display-active indication used in gated mode |
| dot_clk | output | 1 | LCD dot clock |
| upd_en | output | 1 | One-cycle enable preceding each launch edge |

## Verification
The bench measures complete high and low phases for divider values of 1 and above. A design that loads the count off by one would show phases of N±1 cycles, and one with N = 1 mishandled would stop toggling. It checks that upd_en lines up with the transition direction chosen by launch_rise. A polarity swap or a one-cycle skew would put the pulse before the wrong edge or after it. The divider is reprogrammed in the middle of a high phase to catch a design that applies the new value at once and so truncates a phase. The bench also confirms that the gated mode holds the clock low both with the divider in use and in bypass, and that zero behaves as bypass rather than wrapping into a very long count.

// File: rtl/lcd_dotclk_pkg.sv
package lcd_dotclk_pkg;
  typedef enum logic {
    MODE_ALWAYS = 1'b0,
    MODE_GATED  = 1'b1
  } clk_mode_e;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } launch_edge_e;
endpackage

// File: rtl/lcd_dotclk_div.sv
module lcd_dotclk_div
  import lcd_dotclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             bypass,
  input  logic             launch_rise,
  input  logic             run,
  input  logic             gated,
  input  logic             active,
  output logic             ph_o,
  output logic             upd_o,
  output logic             byp_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cur_div_q, eff_div, cnt_nxt, div_nxt;
  logic             ph_q, upd_q, byp_q, fresh_q;
  logic             byp_now, go, term, ph_nxt, term_nxt, want_ph;

  always_comb begin
    byp_now  = bypass || (div_val == '0);
    go       = run && !byp_now;
    eff_div  = fresh_q ? div_val : cur_div_q;
    term     = (cnt_q == eff_div - ONE);
    cnt_nxt  = term ? '0 : cnt_q + ONE;
    ph_nxt   = term ? ~ph_q : ph_q;
    div_nxt  = (term && !ph_q) ? div_val : eff_div;
    term_nxt = (cnt_nxt == div_nxt - ONE);
    want_ph  = (launch_rise == EDGE_RISE) ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cur_div_q <= ONE;
      ph_q      <= 1'b0;
      upd_q     <= 1'b0;
      byp_q     <= 1'b0;
      fresh_q   <= 1'b1;
    end else begin
      byp_q <= byp_now;
      if (!go) begin
        cnt_q   <= '0;
        ph_q    <= 1'b0;
        fresh_q <= 1'b1;
        upd_q   <= byp_now && run;
      end else begin
        cnt_q     <= cnt_nxt;
        ph_q      <= ph_nxt;
        cur_div_q <= div_nxt;
        fresh_q   <= 1'b0;
        upd_q     <= term_nxt && (ph_nxt == want_ph);
      end
    end
  end

  assign ph_o  = ph_q;
  assign upd_o = upd_q;
  assign byp_o = byp_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !fresh_q |-> (cnt_q < cur_div_q));

  // R4
  upd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !byp_q && go) |=> (ph_q != $past(ph_q)));

  // R6
  gated_low_chk: assert property (@(posedge clk) disable iff (rst)
    (gated && !active) |=> (!ph_q && !upd_q));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !fresh_q && !(term && !ph_q)) |=> (cur_div_q == $past(cur_div_q)));

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!ph_q && !upd_q));
endmodule

// File: rtl/lcd_dotclk_out.sv
module lcd_dotclk_out (
  input  logic clk,
  input  logic rst,
  input  logic byp,
  input  logic run,
  input  logic ph,
  output logic dot_clk
);
  logic gate_n;

  // enable updated while the core clock is low, so the AND cannot glitch
  always_ff @(negedge clk) begin
    if (rst) gate_n <= 1'b0;
    else     gate_n <= run;
  end

  assign dot_clk = byp ? (clk & gate_n) : ph;
endmodule

// File: rtl/lcd_dotclk_gen.sv
module lcd_dotclk_gen
  import lcd_dotclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             bypass,
  input  logic             launch_rise,
  input  logic             clk_gated,
  input  logic             disp_active,
  output logic             dot_clk,
  output logic             upd_en
);
  logic run, ph, byp;

  assign run = (clk_gated == MODE_GATED) ? disp_active : 1'b1;

  lcd_dotclk_div #(.DIV_W(DIV_W)) div_i (
    .clk        (clk),
    .rst        (rst),
    .div_val    (div_val),
    .bypass     (bypass),
    .launch_rise(launch_rise),
    .run        (run),
    .gated      (clk_gated),
    .active     (disp_active),
    .ph_o       (ph),
    .upd_o      (upd_en),
    .byp_o      (byp)
  );

  lcd_dotclk_out out_i (
    .clk    (clk),
    .rst    (rst),
    .byp    (byp),
    .run    (run),
    .ph     (ph),
    .dot_clk(dot_clk)
  );
endmodule

// File: tb/lcd_dotclk_gen_tb.sv
module lcd_dotclk_gen_tb_top;
  localparam int DIV_W = 8;
  localparam int NS = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] div_val = 8'd3;
  logic bypass = 1'b0, launch_rise = 1'b0, clk_gated = 1'b0, disp_active = 1'b0;
  logic dot_clk, upd_en;

  int nchk = 0, nerr = 0;
  logic dc [NS];
  logic up [NS];

  always #4 clk = ~clk;

  lcd_dotclk_gen #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .div_val(div_val), .bypass(bypass),
    .launch_rise(launch_rise), .clk_gated(clk_gated),
    .disp_active(disp_active), .dot_clk(dot_clk), .upd_en(upd_en)
  );

  // {expected half length (0 = core rate), bypass, launch_rise, div_val}
  localparam logic [17:0] VEC [8] = '{
    {8'd3, 1'b0, 1'b0, 8'd3},
    {8'd1, 1'b0, 1'b0, 8'd1},
    {8'd1, 1'b0, 1'b1, 8'd1},
    {8'd5, 1'b0, 1'b1, 8'd5},
    {8'd2, 1'b0, 1'b0, 8'd2},
    {8'd7, 1'b0, 1'b1, 8'd7},
    {8'd0, 1'b0, 1'b0, 8'd0},
    {8'd0, 1'b1, 1'b1, 8'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(!dot_clk && !upd_en, "R8 reset idle", {dot_clk, upd_en}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic capture();
    for (int i = 0; i < NS; i++) begin
      @(posedge clk); #2;
      dc[i] = dot_clk;
      up[i] = upd_en;
    end
  endtask

  task automatic check_div(input int half, input bit rise, input string tag);
    int i, h, l, bad;
    i = 1;
    while (i < NS && !(dc[i-1] == 1'b0 && dc[i] == 1'b1)) i++;
    h = 0;
    while (i < NS && dc[i]) begin h++; i++; end
    l = 0;
    while (i < NS && !dc[i]) begin l++; i++; end
    chk(h == half, {"R1 high phase ", tag}, h, half);
    chk(l == half && i < NS, {"R1 low phase ", tag}, l, half);
    bad = 0;
    for (int k = 0; k < NS - 1; k++)
      if (up[k] != ((dc[k] != dc[k+1]) && (dc[k] == !rise))) bad++;
    chk(bad == 0, {"R4 launch enable alignment ", tag}, bad, 0);
  endtask

  task automatic check_byp(input string tag);
    int bad;
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #2;
      if (dot_clk !== 1'b1 || upd_en !== 1'b1) bad++;
      @(negedge clk); #2;
      if (dot_clk !== 1'b0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int runs [8];
    int nr, cur;
    bit found;

    // vector table, always-running mode with disp_active low (R5)
    for (int v = 0; v < 8; v++) begin
      logic [7:0] half, dv;
      logic byp, rise;
      {half, byp, rise, dv} = VEC[v];
      div_val = dv; bypass = byp; launch_rise = rise;
      clk_gated = 1'b0; disp_active = 1'b0;
      do_reset();
      if (half == 0)
        check_byp(byp ? "R2 bypass follows core clock (R5 always mode)"
                      : "R3 zero divider acts as bypass");
      else begin
        capture();
        check_div(int'(half), rise, $sformatf("N=%0d R5", half));
      end
    end

    // R6: gated mode, divided, inactive then active
    div_val = 8'd3; bypass = 1'b0; launch_rise = 1'b0;
    clk_gated = 1'b1; disp_active = 1'b0;
    do_reset();
    capture();
    cur = 0;
    for (int k = 0; k < NS; k++) if (dc[k] || up[k]) cur++;
    chk(cur == 0, "R6 gated inactive holds low", cur, 0);
    @(negedge clk); disp_active = 1'b1;
    capture();
    check_div(3, 1'b0, "R6 gated active");

    // R6: gated bypass, inactive
    bypass = 1'b1; disp_active = 1'b0;
    repeat (3) @(posedge clk);
    cur = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2;
      if (dot_clk || upd_en) cur++;
    end
    chk(cur == 0, "R6 gated bypass inactive holds low", cur, 0);
    @(negedge clk); disp_active = 1'b1;
    repeat (2) @(posedge clk);
    check_byp("R6 gated bypass active runs");

    // R7: divider change mid high phase
    bypass = 1'b0; clk_gated = 1'b0; div_val = 8'd4; launch_rise = 1'b0;
    do_reset();
    found = 1'b0;
    begin
      logic prev;
      prev = 1'b1;
      for (int k = 0; k < 40 && !found; k++) begin
        @(posedge clk); #2;
        if (!prev && dot_clk) found = 1'b1;
        prev = dot_clk;
      end
    end
    chk(found, "R7 rising edge seen", found, 1);
    @(negedge clk); div_val = 8'd2;
    capture();
    nr = 0; cur = 1;
    for (int k = 1; k < NS; k++) begin
      if (dc[k] == dc[k-1]) cur++;
      else begin
        if (nr < 8) runs[nr] = cur;
        nr++; cur = 1;
      end
    end
    chk(dc[0] == 1'b1 && runs[0] == 3, "R7 old high phase completes", runs[0], 3);
    chk(runs[1] == 4, "R7 old low phase kept", runs[1], 4);
    chk(runs[2] == 2, "R7 new high phase", runs[2], 2);
    chk(runs[3] == 2, "R7 new low phase", runs[3], 2);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule